// File: doc/BRIEF.md
# Saturating Doubling Multiply-High Lane Unit

This block works on one 32-bit beat of a 128-bit vector register per transfer. The beat holds four 8-bit, two 16-bit or one 32-bit signed element. For each element it doubles the product of the two operands and keeps the high half of the result. It can optionally add half of one result step (a rounding constant) before taking the high half. It then clamps the result to the signed range of the element. The second operand comes either from the matching lane of a second vector beat or from a 32-bit scalar. In the scalar case, the low element-size bits of the scalar feed every element.

A 4-bit byte mask, with one bit per byte of the beat, decides which destination bytes take the new result. Bytes whose mask bit is clear keep the previous destination value, which the caller supplies on `destPrev`. A sticky saturation flag records any saturation in an element that the mask enables. The flag stays set until the `qcClear` input is pulsed.

Beats enter under a valid/ready handshake. Each accepted beat appears on the output register in the following cycle, together with its beat index.

Top module: `dmulh_lane_unit`

## Requirements
- R1: After reset, `outValid`, `qcFlag`, `outData` and `outBeat` are all zero.
- R2: With `roundEn`=0, each element result is floor(2·a·b / 2^E), where E is the element width. `elemSize` encodes E as follows: 2'b00 gives 8, with element k in bits [8k+7:8k]; 2'b01 gives 16, with element k in bits [16k+15:16k]; 2'b10 and 2'b11 give 32.
- R3: With `roundEn`=1, each element result is floor((2·a·b + 2^(E-1)) / 2^E).
- R4: A result above the largest signed E-bit value is replaced by that largest value. This happens only when both operands equal the most negative E-bit value.
- R5: With `scalarSel`=1, `opB[E-1:0]` is the second operand of every element. With `scalarSel`=0, element k of `opB` is used.
- R6: Output byte i (bits [8i+7:8i]) takes the computed byte when `byteMask[i]`=1. Otherwise it takes byte i of `destPrev`.
- R7: `qcFlag` becomes 1 in the cycle after accepting a beat in which some element k saturated and `byteMask[k·E/8]`=1. A saturated element whose mask bit is 0 leaves the flag unchanged.
- R8: `qcFlag` stays at 1 until `qcClear` is sampled high. When `qcClear` coincides with an accepted beat that sets the flag, the flag stays 1.
- R9: `inReady` = !`outValid` || `outReady`. A beat is accepted when `inValid` && `inReady`. Its result is on `outData` with `outValid`=1 in the next cycle, and it holds stable while `outReady` is 0.
- R10: `outBeat` carries the `beatIdx` of the accepted beat alongside its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat is offered |
| inReady | output | 1 | Unit can take a beat this cycle |
| opA | input | 32 | First operand beat |
| opB | input | 32 | Second operand beat or scalar |
| scalarSel | input | 1 | 1: use the scalar low bits for every element |
| beatIdx | input | 2 | Beat position within the 128-bit register |
| byteMask | input | 4 | Per-byte writeback enable |
| elemSize | input | 2 | Element width code |
| roundEn | input | 1 | Add the rounding constant |
| destPrev | input | 32 | Current destination beat |
| outReady | input | 1 | Consumer takes the output |
| outValid | output | 1 | Output register holds a result |
| outData | output | 32 | Merged destination beat |
| outBeat | output | 2 | Beat index of the result |
| qcClear | input | 1 | Pulse to clear the saturation flag |
| qcFlag | output | 1 | Sticky saturation flag |

## Verification
Saturation needs both operands of an element to be exactly the most negative value at the chosen width. Uniform random operands almost never produce this. The stimulus therefore draws each element from a small set biased toward that value and its neighbours, and it also uses whole beats filled with it.

The hardest cases combine this with mask positions. Examples are a saturating 16-bit upper element whose enabling bit is `byteMask[2]`, and a saturating byte whose mask bit is clear. They also combine it with a clear pulse in the same cycle as a set. Directed beats reach each of these cases before the random phase.

// File: rtl/dmulh_pkg.sv
package dmulh_pkg;
  typedef enum logic [1:0] {
    SZ_B8     = 2'b00,
    SZ_B16    = 2'b01,
    SZ_B32    = 2'b10,
    SZ_B32ALT = 2'b11
  } elemSize_e;

  typedef struct packed {
    logic capture;
    logic clearQc;
  } laneStrobe_t;
endpackage

// File: rtl/dmulh_elem.sv
module dmulh_elem #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         roundEn,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam int PW = 2 * W + 2;
  localparam logic signed [PW-1:0] MAXV = {{(W + 3){1'b0}}, {(W - 1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  logic signed [PW-1:0] aWide, bWide, rndTerm, prod, shifted;

  always_comb begin
    aWide = PW'($signed(a));
    bWide = PW'($signed(b));
    rndTerm = '0;
    if (roundEn) rndTerm[W-1] = 1'b1;
    prod = ((aWide * bWide) <<< 1) + rndTerm;
    shifted = prod >>> W;
    if (shifted > MAXV) begin
      res = MAXV[W-1:0];
      sat = 1'b1;
    end else if (shifted < MINV) begin
      res = MINV[W-1:0];
      sat = 1'b1;
    end else begin
      res = shifted[W-1:0];
      sat = 1'b0;
    end
  end
endmodule

// File: rtl/dmulh_datapath.sv
module dmulh_datapath
  import dmulh_pkg::*;
#(
  parameter int BEAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  laneStrobe_t       strobe,
  input  logic [BEAT_W-1:0] opA,
  input  logic [BEAT_W-1:0] opB,
  input  logic              scalarSel,
  input  logic [1:0]        beatIdx,
  input  logic [BEAT_W/8-1:0] byteMask,
  input  logic [1:0]        elemSize,
  input  logic              roundEn,
  input  logic [BEAT_W-1:0] destPrev,
  output logic [BEAT_W-1:0] outData,
  output logic [1:0]        outBeat,
  output logic              qcFlag
);
  localparam int NB  = BEAT_W / 8;
  localparam int N16 = BEAT_W / 16;
  localparam int N32 = BEAT_W / 32;

  logic [BEAT_W-1:0] res8, res16, res32, chosen, merged;
  logic [NB-1:0]  sat8;
  logic [N16-1:0] sat16;
  logic [N32-1:0] sat32;
  logic satHit;

  for (genvar i = 0; i < NB; i++) begin : g_b8
    dmulh_elem #(.W(8)) i_elem (
      .a(opA[8*i +: 8]),
      .b(scalarSel ? opB[7:0] : opB[8*i +: 8]),
      .roundEn(roundEn),
      .res(res8[8*i +: 8]),
      .sat(sat8[i])
    );
  end

  for (genvar j = 0; j < N16; j++) begin : g_b16
    dmulh_elem #(.W(16)) i_elem (
      .a(opA[16*j +: 16]),
      .b(scalarSel ? opB[15:0] : opB[16*j +: 16]),
      .roundEn(roundEn),
      .res(res16[16*j +: 16]),
      .sat(sat16[j])
    );
  end

  for (genvar k = 0; k < N32; k++) begin : g_b32
    dmulh_elem #(.W(32)) i_elem (
      .a(opA[32*k +: 32]),
      .b(scalarSel ? opB[31:0] : opB[32*k +: 32]),
      .roundEn(roundEn),
      .res(res32[32*k +: 32]),
      .sat(sat32[k])
    );
  end

  // Element select, saturation gated by the mask bit of the element's low byte
  always_comb begin
    satHit = 1'b0;
    case (elemSize)
      SZ_B8: begin
        chosen = res8;
        for (int i = 0; i < NB; i++) satHit = satHit | (sat8[i] & byteMask[i]);
      end
      SZ_B16: begin
        chosen = res16;
        for (int j = 0; j < N16; j++) satHit = satHit | (sat16[j] & byteMask[2*j]);
      end
      default: begin
        chosen = res32;
        for (int k = 0; k < N32; k++) satHit = satHit | (sat32[k] & byteMask[4*k]);
      end
    endcase
    for (int i = 0; i < NB; i++)
      merged[8*i +: 8] = byteMask[i] ? chosen[8*i +: 8] : destPrev[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outData <= '0;
      outBeat <= '0;
      qcFlag  <= 1'b0;
    end else begin
      if (strobe.capture) begin
        outData <= merged;
        outBeat <= beatIdx;
      end
      if (strobe.capture && satHit) qcFlag <= 1'b1;
      else if (strobe.clearQc)      qcFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/dmulh_ctrl.sv
module dmulh_ctrl
  import dmulh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        qcClear,
  output logic        inReady,
  output logic        outValid,
  output laneStrobe_t strobe
);
  logic accept;

  assign inReady        = !outValid || outReady;
  assign accept         = inValid && inReady;
  assign strobe.capture = accept;
  assign strobe.clearQc = qcClear;

  always_ff @(posedge clk) begin
    if (!rst_n)        outValid <= 1'b0;
    else if (accept)   outValid <= 1'b1;
    else if (outReady) outValid <= 1'b0;
  end
endmodule

// File: rtl/dmulh_lane_unit.sv
module dmulh_lane_unit
  import dmulh_pkg::*;
#(
  parameter int BEAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [BEAT_W-1:0] opA,
  input  logic [BEAT_W-1:0] opB,
  input  logic              scalarSel,
  input  logic [1:0]        beatIdx,
  input  logic [BEAT_W/8-1:0] byteMask,
  input  logic [1:0]        elemSize,
  input  logic              roundEn,
  input  logic [BEAT_W-1:0] destPrev,
  input  logic              outReady,
  output logic              outValid,
  output logic [BEAT_W-1:0] outData,
  output logic [1:0]        outBeat,
  input  logic              qcClear,
  output logic              qcFlag
);
  laneStrobe_t strobe;

  dmulh_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .outReady(outReady),
    .qcClear(qcClear), .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  dmulh_datapath #(.BEAT_W(BEAT_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opA(opA), .opB(opB),
    .scalarSel(scalarSel), .beatIdx(beatIdx), .byteMask(byteMask),
    .elemSize(elemSize), .roundEn(roundEn), .destPrev(destPrev),
    .outData(outData), .outBeat(outBeat), .qcFlag(qcFlag)
  );
endmodule

// File: rtl/dmulh_lane_checker.sv
module dmulh_lane_checker #(
  parameter int BEAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              inReady,
  input logic [BEAT_W/8-1:0] byteMask,
  input logic [BEAT_W-1:0] destPrev,
  input logic              outReady,
  input logic              outValid,
  input logic [BEAT_W-1:0] outData,
  input logic              qcClear,
  input logic              qcFlag
);
  logic [BEAT_W-1:0] keepBits;
  always_comb
    for (int i = 0; i < BEAT_W / 8; i++) keepBits[8*i +: 8] = {8{~byteMask[i]}};

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady |=> outValid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outData)); // R9
  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady |=> ((outData ^ $past(destPrev)) & $past(keepBits)) == '0); // R6
  AST_QC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    qcFlag && !qcClear |=> qcFlag); // R8
  AST_QC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    qcClear && !(inValid && inReady) |=> !qcFlag); // R8
  AST_QC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qcFlag) |-> $past(inValid && inReady)); // R7
endmodule

bind dmulh_lane_unit dmulh_lane_checker #(.BEAT_W(BEAT_W)) i_chk (.*);

// File: tb/test_dmulh_lane_unit.sv
module test_dmulh_lane_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, scalarSel = 1'b0, roundEn = 1'b0, outReady = 1'b0, qcClear = 1'b0;
  logic [31:0] opA = '0, opB = '0, destPrev = '0;
  logic [1:0] beatIdx = '0, elemSize = '0;
  logic [3:0] byteMask = '0;
  logic inReady, outValid, qcFlag;
  logic [31:0] outData;
  logic [1:0] outBeat;

  int nCmp = 0, nBad = 0;
  bit running = 0, done = 0;

  // reference state
  bit mValid = 0, mQc = 0;
  logic [31:0] mData = '0;
  logic [1:0] mBeat = '0;

  always #2 clk = ~clk;

  dmulh_lane_unit i_dmulh_lane_unit (.*);

  // Behavioural element reference: R2 R3 R4 R5 R6 R7
  task automatic refBeat(input logic [31:0] a, input logic [31:0] b, input bit sc,
                         input logic [1:0] sz, input bit rn, input logic [31:0] prev,
                         input logic [3:0] m, output logic [31:0] res, output bit hit);
    int es;
    longint raw;
    logic signed [127:0] av, bv, p, r, maxv;
    es = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    raw = 0;
    hit = 0;
    for (int e = 0; e < 32 / es; e++) begin
      longint fa, fb;
      bit sat;
      fa = (longint'(a) >> (e * es)) & ((64'sd1 <<< es) - 1);
      fb = sc ? (longint'(b) & ((64'sd1 <<< es) - 1))
              : ((longint'(b) >> (e * es)) & ((64'sd1 <<< es) - 1));
      if (fa >= (64'sd1 <<< (es - 1))) fa = fa - (64'sd1 <<< es);
      if (fb >= (64'sd1 <<< (es - 1))) fb = fb - (64'sd1 <<< es);
      av = 128'(fa);
      bv = 128'(fb);
      p = 2 * av * bv;
      if (rn) p = p + (128'sd1 <<< (es - 1));
      r = p >>> es;
      maxv = (128'sd1 <<< (es - 1)) - 1;
      sat = 0;
      if (r > maxv) begin r = maxv; sat = 1; end
      if (r < -maxv - 1) begin r = -maxv - 1; sat = 1; end
      raw = raw | ((longint'(r) & ((64'sd1 <<< es) - 1)) << (e * es));
      if (sat && m[(e * es) / 8]) hit = 1;
    end
    for (int i = 0; i < 4; i++)
      res[8*i +: 8] = m[i] ? raw[8*i +: 8] : prev[8*i +: 8];
  endtask

  // Cycle model: R8 R9 R10
  always @(posedge clk) begin
    if (!rst_n) begin
      mValid = 0; mQc = 0; mData = '0; mBeat = '0;
    end else begin
      bit acc, hit;
      logic [31:0] res;
      acc = inValid && (!mValid || outReady);
      refBeat(opA, opB, scalarSel, elemSize, roundEn, destPrev, byteMask, res, hit);
      if (acc && hit) mQc = 1;
      else if (qcClear) mQc = 0;
      if (acc) begin mValid = 1; mData = res; mBeat = beatIdx; end
      else if (outReady) mValid = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (running) begin
    check("R9 outValid", 32'(outValid), 32'(mValid));
    check("R9 inReady", 32'(inReady), 32'(!mValid || outReady));
    check("R2 R3 R4 R5 R6 outData", outData, mData);
    check("R10 outBeat", 32'(outBeat), 32'(mBeat));
    check("R7 R8 qcFlag", 32'(qcFlag), 32'(mQc));
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  task automatic beat(input logic [31:0] a, input logic [31:0] b, input bit sc,
                      input logic [1:0] sz, input bit rn, input logic [3:0] m,
                      input bit v, input bit rdy, input bit clr);
    @(posedge clk); #1;
    opA = a; opB = b; scalarSel = sc; elemSize = sz; roundEn = rn; byteMask = m;
    inValid = v; outReady = rdy; qcClear = clr;
    destPrev = $urandom; beatIdx = 2'($urandom);
  endtask

  function automatic logic [31:0] pickOp(input logic [1:0] sz);
    int es = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    logic [31:0] w = '0;
    for (int e = 0; e < 32 / es; e++) begin
      logic [31:0] f;
      case ($urandom_range(0, 4))
        0, 1: f = 32'(1) << (es - 1);          // most negative
        2: f = (32'(1) << (es - 1)) - 1;       // most positive
        3: f = 32'(1) << (es - 1) | 32'd1;
        default: f = $urandom;
      endcase
      w = w | ((f & ((es == 32) ? 32'hFFFF_FFFF : ((32'(1) << es) - 1))) << (e * es));
    end
    return w;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 outValid", 32'(outValid), 32'd0);
    check("R1 qcFlag", 32'(qcFlag), 32'd0);
    check("R1 outData", outData, 32'd0);
    check("R1 outBeat", 32'(outBeat), 32'd0);
    rst_n = 1'b1;
    running = 1;
    // R4 R7: all bytes saturate, fully enabled
    beat(32'h8080_8080, 32'h8080_8080, 0, 2'b00, 0, 4'hF, 1, 1, 0);
    // R8: clear with no beat
    beat(32'h0, 32'h0, 0, 2'b00, 0, 4'hF, 0, 1, 1);
    // R6 R7: byte 1 saturates but its mask bit is clear
    beat(32'h0000_8000, 32'h0000_8000, 0, 2'b00, 0, 4'b1101, 1, 1, 0);
    // R7: upper 16-bit element saturates, enabled by byteMask[2]
    beat(32'h8000_1234, 32'h8000_7FFF, 0, 2'b01, 1, 4'b0100, 1, 1, 0);
    // R8: clear and set in the same cycle
    beat(32'h8000_0000, 32'h8000_0000, 0, 2'b10, 0, 4'h1, 1, 1, 1);
    beat(32'h0, 32'h0, 0, 2'b00, 0, 4'h0, 0, 1, 1);
    // R3 R5: scalar, rounding, 32-bit and 8-bit
    beat(32'h4000_0001, 32'hFFFF_C000, 1, 2'b11, 1, 4'hF, 1, 1, 0);
    beat(32'h7F01_80FF, 32'h1234_5681, 1, 2'b00, 1, 4'hF, 1, 1, 0);
    beat(32'h7F01_80FF, 32'h1234_5681, 1, 2'b00, 0, 4'hF, 1, 1, 0);
    // R9: stall with pending input
    beat(32'h1111_2222, 32'h3333_4444, 0, 2'b01, 0, 4'hF, 1, 0, 0);
    beat(32'h5555_6666, 32'h7777_8888, 0, 2'b01, 0, 4'hF, 1, 0, 0);
    beat(32'h5555_6666, 32'h7777_8888, 0, 2'b01, 0, 4'hF, 1, 1, 0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] sz;
      sz = 2'($urandom);
      beat(pickOp(sz), pickOp(sz), ($urandom_range(0, 3) == 0), sz, 1'($urandom),
           ($urandom_range(0, 2) == 0) ? 4'hF : 4'($urandom),
           ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 9) == 0));
    end
    beat(32'h0, 32'h0, 0, 2'b00, 0, 4'h0, 0, 1, 0);
    @(posedge clk); #1;
    @(negedge clk); #1;
    running = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule